// File: doc/BRIEF.md
# SDLC Idle Line Generator

This block decides, one byte at a time, what an SDLC transmitter places on the line when no frame data is pending. Each idle byte is either a complete flag (`0111_1110` for the default 8-bit width) or a complete byte of ones (mark idle). The choice comes from a mark-select register. A write strobe updates that register, and both the hardware reset and the channel reset clear it. While the transmitter is in loop mode, the block always produces flags. The programmed select value is kept during loop mode and comes back into force once loop mode ends.

Bytes go to the transmit shift path through a valid/ready handshake. When a frame becomes pending, the next byte the block loads is an opening flag, whatever the select setting. After the shift path accepts that flag, the block stops offering bytes so that frame logic can drive the line. When a closing-flag-done strobe arrives, idle generation resumes. The frame body, CRC, zero insertion and line coding are handled by other blocks.

Top module: `sdlc_idle_gen`

## Requirements
- R1: With the select register at 0 and loop mode inactive, every idle byte loaded is the flag pattern 8'h7E (bits 7..0 = 0111_1110).
- R2: With the select register at 1 and loop mode inactive, every idle byte loaded is 8'hFF. This includes the idle bytes that follow a frame's closing flag.
- R3: While `idle_valid` is high and `idle_ready` is low, `idle_byte` and `idle_valid` hold steady. Every byte offered is either 8'h7E or 8'hFF.
- R4: A select write (`sel_wr` high at a clock edge) takes effect only for bytes loaded at later edges. A byte that is already waiting is never changed by it.
- R5: A byte loaded while `loop_active` is high is 8'h7E, whatever the select register holds.
- R6: Writes made during loop mode are stored. The first idle byte loaded after `loop_active` falls uses the stored value.
- R7: If `frame_req` is high when the next byte is loaded in the idle state, that byte is the opening flag 8'h7E, even with mark idle selected.
- R8: Once the opening flag is accepted, `idle_valid` stays low until `close_done` is seen. On the edge after that, an idle byte is loaded.
- R9: `rst` or `chan_rst` high at an edge clears the select register and `idle_valid`. The first byte after release is 8'h7E.
- R10: A byte transfers at an edge where `idle_valid` and `idle_ready` are both high. A new byte is loaded at that same edge (in idle) or whenever `idle_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| chan_rst | input | 1 | Synchronous active-high channel reset |
| sel_wr | input | 1 | Write strobe for the mark-select register |
| sel_wdata | input | 1 | Select value to write (0 flag idle, 1 mark idle) |
| loop_active | input | 1 | Loop mode indication |
| frame_req | input | 1 | A frame is pending and needs an opening flag |
| close_done | input | 1 | Strobe: the closing flag of the frame has been sent |
| idle_ready | input | 1 | Shift path can take a byte |
| idle_valid | output | 1 | `idle_byte` holds a byte to transfer |
| idle_byte | output | 8 | Idle or opening-flag byte |

## Verification
Each output register is loaded at a clock edge from the inputs sampled at that edge. A byte choice driven by `loop_active` or `frame_req` is therefore visible one edge after the input changes. A select write is visible only at the second edge, because the byte loaded at the write's own edge still uses the old value. The bench drives inputs on the falling edge and samples on the falling edge after the counted rising edges. It checks that waiting bytes stay put across several stalled cycles. It also sweeps every combination of the select value and loop mode.

// File: rtl/sdlc_idle_pkg.sv
package sdlc_idle_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_FRAME = 2'd2
    } idle_state_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_IDLE = 2'd1,
        CMD_FLAG = 2'd2,
        CMD_DROP = 2'd3
    } stage_cmd_e;

    typedef struct packed {
        stage_cmd_e  cmd;
        idle_state_e nxt;
    } seq_step_t;

endpackage

// File: rtl/idle_sel_reg.sv
module idle_sel_reg (
    input  logic clk,
    input  logic rst,
    input  logic chan_rst,
    input  logic wr,
    input  logic wdata,
    output logic sel_q
);
    always_ff @(posedge clk) begin
        if (rst || chan_rst) sel_q <= 1'b0;
        else if (wr)         sel_q <= wdata;
    end

    // R9
    sel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        chan_rst |=> !sel_q);

    // R4
    sel_write_chk: assert property (@(posedge clk) disable iff (rst || chan_rst)
        wr |=> (sel_q == $past(wdata)));
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
    import sdlc_idle_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_rst,
    input  logic       frame_req,
    input  logic       close_done,
    input  logic       out_valid,
    input  logic       out_ready,
    output stage_cmd_e cmd
);
    idle_state_e state_q;
    seq_step_t   step;
    logic        load_ok;

    assign load_ok = !out_valid || out_ready;

    always_comb begin
        step.cmd = CMD_HOLD;
        step.nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_ok) begin
                    step.cmd = frame_req ? CMD_FLAG : CMD_IDLE;
                    step.nxt = frame_req ? ST_OPEN : ST_IDLE;
                end
            end
            ST_OPEN: begin
                if (out_valid && out_ready) begin
                    step.cmd = CMD_DROP;
                    step.nxt = ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (out_valid) step.cmd = CMD_DROP;
                if (close_done) step.nxt = ST_IDLE;
            end
            default: step.nxt = ST_IDLE;
        endcase
    end

    assign cmd = step.cmd;

    always_ff @(posedge clk) begin
        if (rst || chan_rst) state_q <= ST_IDLE;
        else                 state_q <= step.nxt;
    end

    // R7
    open_flag_chk: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (state_q == ST_IDLE && frame_req && load_ok) |=> (state_q == ST_OPEN));

    // R8
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (state_q == ST_FRAME && !close_done) |=> (state_q == ST_FRAME && !out_valid));
endmodule

// File: rtl/idle_byte_stage.sv
module idle_byte_stage
    import sdlc_idle_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_rst,
    input  stage_cmd_e        cmd,
    input  logic              sel_q,
    input  logic              loop_active,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    localparam logic [BYTE_W-1:0] FLAG_PAT = {1'b0, {(BYTE_W-2){1'b1}}, 1'b0};
    localparam logic [BYTE_W-1:0] MARK_PAT = {BYTE_W{1'b1}};

    logic mark_eff;
    assign mark_eff = sel_q && !loop_active;

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            out_valid <= 1'b0;
            out_byte  <= FLAG_PAT;
        end else begin
            unique case (cmd)
                CMD_IDLE: begin
                    out_valid <= 1'b1;
                    out_byte  <= mark_eff ? MARK_PAT : FLAG_PAT;
                end
                CMD_FLAG: begin
                    out_valid <= 1'b1;
                    out_byte  <= FLAG_PAT;
                end
                CMD_DROP: out_valid <= 1'b0;
                default:  out_valid <= out_valid;
            endcase
        end
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R3
    pattern_chk: assert property (@(posedge clk) disable iff (rst || chan_rst)
        out_valid |-> (out_byte == FLAG_PAT || out_byte == MARK_PAT));

    // R5
    loop_flag_chk: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (cmd == CMD_IDLE && loop_active) |=> (out_byte == FLAG_PAT));
endmodule

// File: rtl/sdlc_idle_gen.sv
module sdlc_idle_gen
    import sdlc_idle_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_rst,
    input  logic              sel_wr,
    input  logic              sel_wdata,
    input  logic              loop_active,
    input  logic              frame_req,
    input  logic              close_done,
    input  logic              idle_ready,
    output logic              idle_valid,
    output logic [BYTE_W-1:0] idle_byte
);
    logic       sel_q;
    stage_cmd_e cmd;

    idle_sel_reg u_sel (
        .clk      (clk),
        .rst      (rst),
        .chan_rst (chan_rst),
        .wr       (sel_wr),
        .wdata    (sel_wdata),
        .sel_q    (sel_q)
    );

    idle_seq_fsm u_seq (
        .clk        (clk),
        .rst        (rst),
        .chan_rst   (chan_rst),
        .frame_req  (frame_req),
        .close_done (close_done),
        .out_valid  (idle_valid),
        .out_ready  (idle_ready),
        .cmd        (cmd)
    );

    idle_byte_stage #(.BYTE_W(BYTE_W)) u_stage (
        .clk         (clk),
        .rst         (rst),
        .chan_rst    (chan_rst),
        .cmd         (cmd),
        .sel_q       (sel_q),
        .loop_active (loop_active),
        .out_ready   (idle_ready),
        .out_valid   (idle_valid),
        .out_byte    (idle_byte)
    );

    // R10
    reload_chk: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (idle_valid && idle_ready && !frame_req && !loop_active && sel_q && !sel_wr
         && cmd == CMD_IDLE) |=> (idle_valid && idle_byte == {BYTE_W{1'b1}}));
endmodule

// File: tb/sdlc_idle_gen_tb.sv
module sdlc_idle_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chan_rst = 1'b0;
    logic       sel_wr = 1'b0;
    logic       sel_wdata = 1'b0;
    logic       loop_active = 1'b0;
    logic       frame_req = 1'b0;
    logic       close_done = 1'b0;
    logic       idle_ready = 1'b1;
    logic       idle_valid;
    logic [7:0] idle_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] FLAG = 8'h7E;
    localparam logic [7:0] ONES = 8'hFF;

    always #4 clk = ~clk;

    sdlc_idle_gen u_dut (
        .clk(clk), .rst(rst), .chan_rst(chan_rst), .sel_wr(sel_wr),
        .sel_wdata(sel_wdata), .loop_active(loop_active), .frame_req(frame_req),
        .close_done(close_done), .idle_ready(idle_ready),
        .idle_valid(idle_valid), .idle_byte(idle_byte)
    );

    task automatic chk(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual {valid,byte}=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input logic v, input logic [7:0] b, input string tag);
        chk(idle_valid === v && (!v || idle_byte === b), tag,
            {idle_valid, idle_byte}, {v, b});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_sel(input logic v);
        sel_wr = 1'b1;
        sel_wdata = v;
        step();
        sel_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step();
        step();
        chk_out(1'b0, FLAG, "R9 reset clears valid");
        rst = 1'b0;
        step();
        chk_out(1'b1, FLAG, "R1 R9 first byte after reset is flag");

        // select x loop sweep
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 2; l++) begin
                loop_active = l[0];
                write_sel(m[0]);
                step();
                for (int k = 0; k < 4; k++) begin
                    chk_out(1'b1, (m == 1 && l == 0) ? ONES : FLAG,
                            (m == 1 && l == 0) ? "R2 mark idle" :
                            (l == 1) ? "R5 loop forces flag" : "R1 flag idle");
                    step();
                end
            end
        end
        loop_active = 1'b0;
        write_sel(1'b0);
        step();
        chk_out(1'b1, FLAG, "R1 back to flag idle");

        // R4: write while a byte is waiting
        idle_ready = 1'b0;
        step();
        write_sel(1'b1);
        for (int k = 0; k < 3; k++) begin
            chk_out(1'b1, FLAG, "R4 R3 waiting byte unchanged by write");
            step();
        end
        idle_ready = 1'b1;
        step();
        chk_out(1'b1, ONES, "R4 R10 new select at next load");

        // R4: write lands at same edge as a load
        write_sel(1'b0);
        chk_out(1'b1, ONES, "R4 byte loaded at write edge uses old select");
        step();
        chk_out(1'b1, FLAG, "R4 following byte uses new select");

        // R6: store during loop, apply on exit
        loop_active = 1'b1;
        write_sel(1'b1);
        chk_out(1'b1, FLAG, "R5 loop ignores select");
        step();
        chk_out(1'b1, FLAG, "R6 stored select not used in loop");
        loop_active = 1'b0;
        step();
        chk_out(1'b1, ONES, "R6 stored select applies after loop");

        // R7/R8 with ready high
        frame_req = 1'b1;
        step();
        chk_out(1'b1, FLAG, "R7 opening flag under mark idle");
        frame_req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk_out(1'b0, FLAG, "R8 valid low during frame");
        end
        close_done = 1'b1;
        step();
        close_done = 1'b0;
        chk_out(1'b0, FLAG, "R8 valid low on close edge");
        step();
        chk_out(1'b1, ONES, "R8 R2 mark idle after closing flag");

        // R7 with a stalled idle byte
        idle_ready = 1'b0;
        frame_req = 1'b1;
        step();
        chk_out(1'b1, ONES, "R3 stalled mark byte kept whole");
        step();
        chk_out(1'b1, ONES, "R3 stalled mark byte kept whole");
        idle_ready = 1'b1;
        step();
        chk_out(1'b1, FLAG, "R7 R10 flag after stalled byte transfers");
        idle_ready = 1'b0;
        step();
        chk_out(1'b1, FLAG, "R3 opening flag held while not ready");
        idle_ready = 1'b1;
        frame_req = 1'b0;
        step();
        chk_out(1'b0, FLAG, "R8 valid drops after flag accepted");
        close_done = 1'b1;
        step();
        close_done = 1'b0;
        step();
        chk_out(1'b1, ONES, "R8 idle resumes");

        // R9 channel reset
        chan_rst = 1'b1;
        step();
        chan_rst = 1'b0;
        chk_out(1'b0, FLAG, "R9 channel reset clears valid");
        step();
        chk_out(1'b1, FLAG, "R9 channel reset clears select");
        step();
        chk_out(1'b1, FLAG, "R9 flag idle persists");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule